// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Steered Phase Accumulator

This block is one channel of a numerically controlled divider. It runs on a fast input clock and emits a single-cycle enable pulse, `tick`, whose long-term rate is an exact fraction of the input rate. Each output period has a base length in half input cycles, taken from a divisor setting. That length grows by one half cycle whenever the most significant bit of a 32-bit phase accumulator is set. At every output pulse the accumulator adds one of two programmed increments. Its own top bit picks which one, so a small positive step and a wrapped negative step steer it around the midpoint.

Software writes the divisor, both increments and the accumulator start value while the channel is stopped, and then sets the run bit. A half input cycle left over at the end of a period carries into the next one, so the output stays a clean one-cycle pulse in the input clock domain. The average period is still correct to the half cycle. A typical start value is 0x8000_0000.

Top module: `nco_frac_div`

## Requirements
- R1: After reset the channel is stopped, `tick` is low, and every setting register reads as zero in effect (no pulse appears until the channel is started).
- R2: Bit 31 of the word at offset 0x00 is the run bit. While it is clear no pulse is produced, starting with the cycle after the write that clears it.
- R3: While the accumulator top bit is clear, a period lasts divisor/2 input cycles. The first pulse after a start comes ceil(L/2) cycles after the starting edge, where L is the length in half cycles.
- R4: While the accumulator top bit is set, the period lasts (divisor+1) half cycles. Half cycles carry across periods, so pulse n falls on cycle ceil(S_n/2), with S_n the running sum of the period lengths in half cycles.
- R5: At each pulse the accumulator adds the word at offset 0x08 when its top bit is clear, or the word at offset 0x0C when it is set. The top bit after that addition sets the next period's length. Between pulses the accumulator holds.
- R6: A change of the run bit from 0 to 1 loads the accumulator from the word at offset 0x10 and restarts the period count from the divisor.
- R7: Writes to offsets 0x04, 0x08, 0x0C and 0x10 while running leave the running pattern untouched and take effect at the next 0-to-1 start. Writing the run bit as 1 again while running does not restart the channel.
- R8: Divisor values below 4 behave as 4.
- R9: In the word at offset 0x04, bits [12:2] are a coarse part and bits [1:0] a fine part, giving a divisor of coarse*4+fine. Bits [31:13] are ignored, and writes to offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 have no effect.
- R10: `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the written register |
| wr_data | input | 32 | Write data |
| tick | output | 1 | One-cycle output clock enable |

## Verification
Several fixed patterns each isolate one path. With both increments zero and a clear top bit, the spacing is constant. The same with a set top bit gives alternating spacing that exposes the half-cycle carry. A symmetric pair of increments alternates the lengthened and plain periods, which shows whether the increment is chosen by the right bit. A divisor below the floor, and a divisor word with set upper bits and set fine bits, show the clamp and the field decode. A run interrupted by setting writes, a redundant start and a stop separates held settings from live ones. Seeded random divisors, increment pairs and start values then compare every pulse position against a bench model that sums half-cycle lengths.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int ACC_W  = 32;
    localparam int DIV_W  = 13;
    localparam int HALF_W = DIV_W + 1;
    localparam int RUN_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] OFS_DIV  = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] OFS_INCC = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] OFS_INCS = ADDR_W'(5'h0C);
    localparam logic [ADDR_W-1:0] OFS_SEED = ADDR_W'(5'h10);

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_DIV,
        SEL_INC_CLR,
        SEL_INC_SET,
        SEL_SEED,
        SEL_NONE
    } reg_sel_e;

    // Settings used while the channel runs
    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        logic [ACC_W-1:0] inc_clr;
        logic [ACC_W-1:0] inc_set;
    } run_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFS_CTRL)      s = SEL_CTRL;
        else if (a == OFS_DIV)  s = SEL_DIV;
        else if (a == OFS_INCC) s = SEL_INC_CLR;
        else if (a == OFS_INCS) s = SEL_INC_SET;
        else if (a == OFS_SEED) s = SEL_SEED;
        else                    s = SEL_NONE;
        return s;
    endfunction

    // Period length in half input cycles
    function automatic logic [HALF_W-1:0] half_len(
        input logic [DIV_W-1:0] d,
        input logic             longer,
        input logic [DIV_W-1:0] floor_div
    );
        logic [DIV_W-1:0] eff;
        eff = (d < floor_div) ? floor_div : d;
        return {1'b0, eff} + {{DIV_W{1'b0}}, longer};
    endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output logic              load_o,
    output run_cfg_t          shd_o,
    output logic [ACC_W-1:0]  seed_o,
    output run_cfg_t          act_o
);

    reg_sel_e         sel;
    logic             run_q;
    run_cfg_t         shd_q;
    run_cfg_t         act_q;
    logic [ACC_W-1:0] seed_q;

    assign sel    = decode_addr(wr_addr);
    assign load_o = wr_en && (sel == SEL_CTRL) && wr_data[RUN_BIT] && !run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            shd_q  <= '0;
            act_q  <= '0;
            seed_q <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_CTRL:    run_q         <= wr_data[RUN_BIT];
                    SEL_DIV:     shd_q.divisor <= wr_data[DIV_W-1:0];
                    SEL_INC_CLR: shd_q.inc_clr <= wr_data[ACC_W-1:0];
                    SEL_INC_SET: shd_q.inc_set <= wr_data[ACC_W-1:0];
                    SEL_SEED:    seed_q        <= wr_data[ACC_W-1:0];
                    default:     ;
                endcase
            end
            if (load_o) act_q <= shd_q;
        end
    end

    assign run_o  = run_q;
    assign shd_o  = shd_q;
    assign seed_o = seed_q;
    assign act_o  = act_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] seed,
    input  logic             step,
    input  logic [ACC_W-1:0] inc_clr,
    input  logic [ACC_W-1:0] inc_set,
    output logic             nxt_msb_o,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    // The top bit steers which increment applies
    assign sum = acc_q + (acc_q[ACC_W-1] ? inc_set : inc_clr);

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (load) acc_q <= seed;
        else if (step) acc_q <= sum;
    end

    assign nxt_msb_o = sum[ACC_W-1];
    assign acc_o     = acc_q;

endmodule

// File: rtl/nco_half_seq.sv
module nco_half_seq
    import nco_pkg::*;
#(
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_start,
    input  logic             seed_msb,
    input  logic [DIV_W-1:0] div_act,
    input  logic             nxt_msb,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0]  FLOOR = DIV_W'(MIN_DIV);
    localparam logic [HALF_W-1:0] TWO   = HALF_W'(2);

    // Half cycles left in the current period
    logic [HALF_W-1:0] rem_q;

    assign tick_o = run && (rem_q <= TWO);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= half_len(div_start, seed_msb, FLOOR);
        end else if (tick_o) begin
            // rem_q is 1 or 2; a value of 1 leaves a half cycle for the next period
            rem_q <= half_len(div_act, nxt_msb, FLOOR) + rem_q - TWO;
        end else if (run) begin
            rem_q <= rem_q - TWO;
        end
    end

endmodule

// File: rtl/nco_frac_div.sv
module nco_frac_div
    import nco_pkg::*;
#(
    parameter int MIN_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick
);

    logic             run_w;
    logic             load_w;
    run_cfg_t         shd_w;
    run_cfg_t         act_w;
    logic [ACC_W-1:0] seed_w;
    logic [ACC_W-1:0] acc_w;
    logic             nxt_msb_w;

    nco_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run_o   (run_w),
        .load_o  (load_w),
        .shd_o   (shd_w),
        .seed_o  (seed_w),
        .act_o   (act_w)
    );

    nco_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .seed      (seed_w),
        .step      (tick),
        .inc_clr   (act_w.inc_clr),
        .inc_set   (act_w.inc_set),
        .nxt_msb_o (nxt_msb_w),
        .acc_o     (acc_w)
    );

    nco_half_seq #(.MIN_DIV(MIN_DIV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .run       (run_w),
        .div_start (shd_w.divisor),
        .seed_msb  (seed_w[ACC_W-1]),
        .div_act   (act_w.divisor),
        .nxt_msb   (nxt_msb_w),
        .tick_o    (tick)
    );

endmodule

// File: rtl/nco_frac_div_chk.sv
module nco_frac_div_chk
    import nco_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic [ACC_W-1:0] acc,
    input run_cfg_t         act
);

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_acc_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(acc));

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        run |=> (!run || $stable(act)));

endmodule

bind nco_frac_div nco_frac_div_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (run_w),
    .acc  (acc_w),
    .act  (act_w)
);

// File: tb/sim_nco_frac_div.sv
module sim_nco_frac_div;

    localparam int CLK_PERIOD = 10;
    localparam int SEED = 20240611;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int          m_div = 0;
    logic [31:0] m_inc1 = '0, m_inc2 = '0, m_init = '0, m_acc = '0;
    int          m_sum = 0, m_next = 0, m_k = 0;
    bit          m_run = 1'b0, chk_on = 1'b0;
    int          win_mis = 0, mis_k = 0;
    bit          mis_act = 1'b0, mis_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_frac_div u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick)
    );

    function automatic int hlen(input int d, input bit msb);
        return ((d < 4) ? 4 : d) + int'(msb);
    endfunction

    task automatic nstep();
        bit e;
        @(negedge clk);
        wr_en = 1'b0;
        if (chk_on) begin
            m_k++;
            e = m_run && (m_k == m_next);
            if (e) begin
                m_acc  = m_acc + (m_acc[31] ? m_inc2 : m_inc1);
                m_sum += hlen(m_div, m_acc[31]);
                m_next = (m_sum + 1) / 2;
            end
            if (tick !== e) begin
                if (win_mis == 0) begin
                    mis_k = m_k; mis_act = tick; mis_exp = e;
                end
                win_mis++;
            end
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        nstep();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) nstep();
    endtask

    task automatic open_win();
        chk_on = 1'b1; win_mis = 0;
    endtask

    task automatic close_win(input string req);
        checks++;
        if (win_mis != 0) begin
            fails++;
            $display("FAIL %s: cycle %0d tick actual=%0b expected=%0b (%0d mismatches)",
                     req, mis_k, mis_act, mis_exp, win_mis);
        end
    endtask

    // Writes all settings; the model takes them as the next active set
    task automatic set_cfg(input logic [31:0] divw, input logic [31:0] i1,
                           input logic [31:0] i2, input logic [31:0] ini);
        write_reg(5'h04, divw);
        write_reg(5'h08, i1);
        write_reg(5'h0C, i2);
        write_reg(5'h10, ini);
        m_div = int'(divw[12:2]) * 4 + int'(divw[1:0]);
        m_inc1 = i1; m_inc2 = i2; m_init = ini;
    endtask

    task automatic start_run();
        write_reg(5'h00, 32'h8000_0000);
        m_run = 1'b1; m_k = 0; m_acc = m_init;
        m_sum = hlen(m_div, m_acc[31]);
        m_next = (m_sum + 1) / 2;
    endtask

    task automatic stop_run();
        write_reg(5'h00, 32'h0000_0000);
        m_run = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [31:0] rate, i1, ini;
        int dv;
        unused_seed = $urandom(SEED);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        open_win(); run_cycles(12); close_win("R1 reset state");

        // R2: settings written but not started
        open_win(); set_cfg(32'd8, 32'd0, 32'd0, 32'd0); run_cycles(20);
        close_win("R2 no pulse while stopped");

        // R3: even divisor, top bit clear, fixed spacing of 4
        open_win(); start_run(); run_cycles(60); close_win("R3 plain period");
        open_win(); stop_run(); run_cycles(20); close_win("R2 stop halts pulses");

        // R4: top bit held set, 9 half cycles, spacing 5/4
        open_win(); set_cfg(32'd8, 32'd0, 32'd0, 32'h8000_0000); start_run();
        run_cycles(80); close_win("R4 lengthened period with half-cycle carry");
        stop_run();

        // R5: symmetric increments alternate plain and lengthened periods
        open_win(); set_cfg(32'd10, 32'h4000_0000, 32'hC000_0000, 32'h8000_0000);
        start_run(); run_cycles(120); close_win("R5 increment steering");
        stop_run();

        // R8: divisor 2 and 0 act as 4
        open_win(); set_cfg(32'd2, 32'd0, 32'd0, 32'd0); start_run();
        run_cycles(30); close_win("R8 divisor floor 2"); stop_run();
        open_win(); set_cfg(32'd0, 32'd0, 32'd0, 32'h8000_0000); start_run();
        run_cycles(30); close_win("R8 divisor floor 0"); stop_run();

        // R9: coarse 3, fine 1 -> 13, upper bits ignored, unmapped offsets ignored
        open_win(); set_cfg(32'hFFFF_E000 | ((32'd3 << 2) | 32'd1), 32'h2000_0000,
                            32'hA000_0000, 32'h1000_0000);
        write_reg(5'h14, 32'h0000_0004); write_reg(5'h1C, 32'hFFFF_FFFF);
        write_reg(5'h02, 32'h0000_0000);
        start_run(); run_cycles(120); close_win("R9 divisor fields and unmapped offsets");

        // R7: writes while running are held; repeated start does not restart
        open_win();
        write_reg(5'h04, 32'd20); write_reg(5'h08, 32'd0);
        write_reg(5'h0C, 32'd0);  write_reg(5'h10, 32'd0);
        write_reg(5'h00, 32'h8000_0000);
        run_cycles(80); close_win("R7 held writes and redundant start");
        stop_run();
        m_div = 20; m_inc1 = 32'd0; m_inc2 = 32'd0; m_init = 32'd0;
        open_win(); run_cycles(15); close_win("R2 stopped after held writes");

        // R6: restart applies held settings and reloads the accumulator
        open_win(); start_run(); run_cycles(70); close_win("R6 reload on start");
        stop_run();

        // Random patterns: R3/R4/R5/R6 against the half-cycle sum model
        for (int n = 0; n < 6; n++) begin
            dv   = 4 + int'($urandom % 37);
            rate = 32'h0010_0000 + ($urandom % 32'h3FF0_0000);
            i1   = $urandom % rate;
            ini  = $urandom;
            open_win(); set_cfg(32'(dv), i1, i1 - rate, ini); start_run();
            run_cycles(160); close_win("R4 R5 R6 random pattern");
            stop_run();
        end

        // R10: single-cycle pulse at the fastest setting
        open_win(); set_cfg(32'd4, 32'd0, 32'd0, 32'd0); start_run();
        run_cycles(40); close_win("R10 one-cycle pulses at minimum period");
        stop_run(); run_cycles(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule